// File: doc/BRIEF.md
# Sleep, Wake-Up and Reset-Cause Controller

This block sits beside a small microcontroller core and runs its low-power mode. A sleep instruction strobe stops the oscillator and arms the wake logic. A set of wake sources then restarts the clock and issues a core reset. Three sticky flags record what happened last, so boot code can tell the cause of a restart: a time-out flag, a power-down flag and a pin-change wake flag. Each event leaves a different pattern in these flags.

The watchdog counter itself is outside the block. The block takes the counter's time-out strobe and the watchdog-enable level, and it returns a one-cycle clear pulse. The external reset and the five monitored port inputs are asynchronous and pass through two-flop synchronizers. Port bits 0 to 3 map to `pins_i[3:0]` and port bit 7 maps to `pins_i[4]`. The active-low `rst_ni` is the power-on reset. The brown-out input is synchronous to `clk_i`.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: While `rst_ni` is low and just after it rises, the flags {to,pd,pcw} read 1,1,0, `osc_en_o` is 1 and `sleeping_o` is 0. `core_rst_o` stays high for RST_HOLD cycles after release and then falls.
- R2: A sleep strobe while awake and not in reset has these effects on the next cycle. `sleeping_o` goes to 1 and `osc_en_o` to 0. The flags become to=1, pd=0, pcw=0. `wdt_clr_o` pulses for exactly one cycle.
- R3: A watchdog-clear strobe while awake and not in reset sets to=1 and pd=1 and pulses `wdt_clr_o`. It does not change `sleeping_o`.
- R4: A watchdog time-out while awake with `wdt_en_i`=1 clears `to`, leaves `pd` unchanged and raises `core_rst_o`. With `wdt_en_i`=0 the strobe is ignored.
- R5: An external reset during normal operation raises `core_rst_o` and leaves all three flags unchanged. A sleep strobe given while it is active is ignored.
- R6: An external reset while asleep wakes the block and leaves the flags unchanged.
- R7: A watchdog time-out while asleep wakes the block only when `wdt_en_i`=1. It clears `to` and leaves `pd` at 0.
- R8: With `pcw_en_i`=1, a sleeping block wakes and sets `pcw` once any monitored pin differs from the value it held at sleep entry. With `pcw_en_i`=0, pin changes never wake it.
- R9: Brown-out, asleep or awake, sets the flags to 1,1,0, wakes the block and requests a core reset.
- R10: On every wake, `osc_en_o` rises, `wdt_clr_o` pulses, and `core_rst_o` is high from that cycle for RST_HOLD cycles (at least two).
- R11: A change on `ext_rst_i` or `pins_i` takes effect on outputs after the third rising clock edge, not earlier.
- R12: While asleep, sleep and watchdog-clear strobes have no effect on the flags or on `sleeping_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| brownout_i | input | 1 | Brown-out detected, synchronous |
| ext_rst_i | input | 1 | External reset pin, asynchronous |
| wdt_to_i | input | 1 | Watchdog time-out strobe |
| wdt_en_i | input | 1 | Watchdog enabled |
| sleep_i | input | 1 | Sleep instruction strobe |
| clrwdt_i | input | 1 | Watchdog-clear instruction strobe |
| pcw_en_i | input | 1 | Wake-on-pin-change enable |
| pins_i | input | NPINS | Monitored port inputs, asynchronous |
| to_flag_o | output | 1 | Time-out flag |
| pd_flag_o | output | 1 | Power-down flag |
| pcw_flag_o | output | 1 | Pin-change wake flag |
| wdt_clr_o | output | 1 | Watchdog clear pulse |
| osc_en_o | output | 1 | Oscillator enable |
| core_rst_o | output | 1 | Reset request to the core |
| sleeping_o | output | 1 | Block is asleep |

## Verification
The bench sweeps all 32 pin patterns at sleep entry against all five single-pin flips. A design that compared against a fixed value, or that took its snapshot a cycle late, would either miss wakes or wake at once. The bench samples one cycle before the expected wake. This exposes a synchronizer that is too short or a wake that fires early. Each reset and wake source is checked against its own flag pattern. A watchdog strobe is also given with the watchdog disabled, and strobes are given while asleep. A decode with wrong priority would corrupt `to` or `pd`, or leave the block stuck asleep. Reset-hold length is checked at its exact end cycle, so an off-by-one in the counter shows up.

// File: rtl/sw_pkg.sv
package sw_pkg;
  typedef struct packed {
    logic to;
    logic pd;
    logic pcw;
  } flags_t;

  localparam flags_t FLAGS_POR = '{to: 1'b1, pd: 1'b1, pcw: 1'b0};
endpackage

// File: rtl/sw_sync.sv
module sw_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
      end else begin
        s1 <= d_i[i];
        s2 <= s1;
      end
    end
    assign q_o[i] = s2;
  end
endmodule

// File: rtl/sw_pin_watch.sv
module sw_pin_watch #(
  parameter int W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         capture_i,
  input  logic [W-1:0] pins_i,
  output logic         diff_o
);
  logic [W-1:0] snap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) snap_q <= '0;
    else if (capture_i) snap_q <= pins_i;
  end

  assign diff_o = |(pins_i ^ snap_q);

  // Right after capture, an unchanged pin set must compare equal.
  assert_snap_match_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(capture_i) && $stable(pins_i)) |-> !diff_o);
endmodule

// File: rtl/sw_flags.sv
module sw_flags
  import sw_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   bor_i,
  input  logic   sleep_go_i,
  input  logic   clr_i,
  input  logic   wdt_hit_i,
  input  logic   pin_hit_i,
  output flags_t flags_o
);
  flags_t q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= FLAGS_POR;
    else if (bor_i) q <= FLAGS_POR;
    else if (sleep_go_i) q <= '{to: 1'b1, pd: 1'b0, pcw: 1'b0};
    else if (clr_i) begin
      q.to <= 1'b1;
      q.pd <= 1'b1;
    end else begin
      if (wdt_hit_i) q.to <= 1'b0;
      if (pin_hit_i) q.pcw <= 1'b1;
    end
  end

  assign flags_o = q;

  assert_sleep_flags_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_go_i && !bor_i) |=> (flags_o.to && !flags_o.pd && !flags_o.pcw));
  assert_clr_flags_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !bor_i && !sleep_go_i) |=> (flags_o.to && flags_o.pd));
  assert_wdt_flags_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdt_hit_i && !bor_i && !sleep_go_i && !clr_i) |=> (!flags_o.to && $stable(flags_o.pd)));
  assert_bor_flags_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bor_i |=> (flags_o.to && flags_o.pd && !flags_o.pcw));
endmodule

// File: rtl/sw_pwr_seq.sv
module sw_pwr_seq #(
  parameter int RST_HOLD = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sleep_go_i,
  input  logic wake_i,
  input  logic rst_ev_i,
  input  logic clr_i,
  output logic sleeping_o,
  output logic osc_en_o,
  output logic core_rst_o,
  output logic wdt_clr_o
);
  localparam int CW = $clog2(RST_HOLD + 1);
  localparam logic [CW-1:0] HOLD_V = CW'(RST_HOLD);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sleeping_o <= 1'b0;
      osc_en_o   <= 1'b1;
      wdt_clr_o  <= 1'b0;
      cnt_q      <= HOLD_V;
    end else begin
      wdt_clr_o <= sleep_go_i | wake_i | clr_i;
      if (wake_i) begin
        sleeping_o <= 1'b0;
        osc_en_o   <= 1'b1;
      end else if (sleep_go_i) begin
        sleeping_o <= 1'b1;
        osc_en_o   <= 1'b0;
      end
      if (wake_i || rst_ev_i) cnt_q <= HOLD_V;
      else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign core_rst_o = (cnt_q != '0);

  assert_wake_rst_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(osc_en_o) |-> (core_rst_o && wdt_clr_o));
  assert_wake_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(osc_en_o) |=> core_rst_o);
  assert_sleep_entry_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sleeping_o) |-> (!osc_en_o && wdt_clr_o));
endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl
  import sw_pkg::*;
#(
  parameter int NPINS    = 5,
  parameter int RST_HOLD = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             brownout_i,
  input  logic             ext_rst_i,
  input  logic             wdt_to_i,
  input  logic             wdt_en_i,
  input  logic             sleep_i,
  input  logic             clrwdt_i,
  input  logic             pcw_en_i,
  input  logic [NPINS-1:0] pins_i,
  output logic             to_flag_o,
  output logic             pd_flag_o,
  output logic             pcw_flag_o,
  output logic             wdt_clr_o,
  output logic             osc_en_o,
  output logic             core_rst_o,
  output logic             sleeping_o
);
  logic             ext_s;
  logic [NPINS-1:0] pins_s;
  logic             pin_diff;
  logic             wdt_ev, busy, pin_wake, wake, sleep_go, clr_go, rst_ev;
  flags_t           flags;

  sw_sync #(.W(1)) i_ext_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ext_rst_i), .q_o(ext_s)
  );

  sw_sync #(.W(NPINS)) i_pin_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pins_i), .q_o(pins_s)
  );

  // Event decode: brown-out first, then reset sources, then instructions.
  assign wdt_ev   = wdt_to_i & wdt_en_i;
  assign busy     = core_rst_o | ext_s;
  assign pin_wake = sleeping_o & pcw_en_i & pin_diff;
  assign wake     = sleeping_o & (brownout_i | wdt_ev | ext_s | pin_wake);
  assign sleep_go = ~sleeping_o & sleep_i & ~busy & ~wdt_ev & ~brownout_i;
  assign clr_go   = ~sleeping_o & clrwdt_i & ~busy & ~wdt_ev & ~brownout_i & ~sleep_i;
  assign rst_ev   = brownout_i | ext_s | (~sleeping_o & wdt_ev);

  sw_pin_watch #(.W(NPINS)) i_pin_watch (
    .clk_i(clk_i), .rst_ni(rst_ni), .capture_i(sleep_go),
    .pins_i(pins_s), .diff_o(pin_diff)
  );

  sw_flags i_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .bor_i(brownout_i), .sleep_go_i(sleep_go),
    .clr_i(clr_go), .wdt_hit_i(wdt_ev), .pin_hit_i(pin_wake), .flags_o(flags)
  );

  sw_pwr_seq #(.RST_HOLD(RST_HOLD)) i_pwr_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .sleep_go_i(sleep_go), .wake_i(wake),
    .rst_ev_i(rst_ev), .clr_i(clr_go), .sleeping_o(sleeping_o),
    .osc_en_o(osc_en_o), .core_rst_o(core_rst_o), .wdt_clr_o(wdt_clr_o)
  );

  assign to_flag_o  = flags.to;
  assign pd_flag_o  = flags.pd;
  assign pcw_flag_o = flags.pcw;

  assert_ext_keep_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_s && !sleeping_o && !brownout_i && !wdt_ev) |=>
      ($stable(to_flag_o) && $stable(pd_flag_o) && $stable(pcw_flag_o) && !sleeping_o));
  assert_pcw_rise_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pcw_flag_o) |-> ($past(sleeping_o) && $past(pcw_en_i)));
  assert_asleep_ignore_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleeping_o && !wake) |=> (sleeping_o && $stable(to_flag_o) && $stable(pd_flag_o)));
endmodule

// File: tb/test_sleep_wake_ctrl.sv
module test_sleep_wake_ctrl;
  localparam int NP   = 5;
  localparam int HOLD = 3;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic brownout_i = 1'b0, ext_rst_i = 1'b0, wdt_to_i = 1'b0, wdt_en_i = 1'b0;
  logic sleep_i = 1'b0, clrwdt_i = 1'b0, pcw_en_i = 1'b0;
  logic [NP-1:0] pins_i = '0;
  logic to_flag_o, pd_flag_o, pcw_flag_o, wdt_clr_o, osc_en_o, core_rst_o, sleeping_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  sleep_wake_ctrl #(.NPINS(NP), .RST_HOLD(HOLD)) i_sleep_wake_ctrl (.*);

  task automatic cyc(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] fl();
    return {to_flag_o, pd_flag_o, pcw_flag_o};
  endfunction

  initial begin
    cyc(3);
    chk("R1 flags in reset", fl(), 3'b110);
    chk("R1 osc in reset", osc_en_o, 1);
    rst_ni = 1'b1;
    chk("R1 sleeping after reset", sleeping_o, 0);
    cyc(HOLD - 1);
    chk("R1 core_rst held", core_rst_o, 1);
    cyc(1);
    chk("R1 core_rst released", core_rst_o, 0);

    // R4 watchdog time-out awake
    wdt_en_i = 1'b1; wdt_to_i = 1'b1; cyc(1); wdt_to_i = 1'b0;
    chk("R4 wdt flags", fl(), 3'b010);
    chk("R4 wdt reset", core_rst_o, 1);
    cyc(HOLD);
    chk("R4 reset ends", core_rst_o, 0);

    // R3 watchdog clear
    clrwdt_i = 1'b1; cyc(1); clrwdt_i = 1'b0;
    chk("R3 clr flags", fl(), 3'b110);
    chk("R3 clr pulse", wdt_clr_o, 1);
    chk("R3 still awake", sleeping_o, 0);
    cyc(1);
    chk("R3 pulse one cycle", wdt_clr_o, 0);

    // R4 disabled watchdog ignored
    wdt_en_i = 1'b0; wdt_to_i = 1'b1; cyc(1); wdt_to_i = 1'b0;
    chk("R4 disabled flags", fl(), 3'b110);
    chk("R4 disabled no reset", core_rst_o, 0);

    // R2 sleep entry
    sleep_i = 1'b1; cyc(1); sleep_i = 1'b0;
    chk("R2 sleep flags", fl(), 3'b100);
    chk("R2 sleeping", sleeping_o, 1);
    chk("R2 osc off", osc_en_o, 0);
    chk("R2 clr pulse", wdt_clr_o, 1);
    cyc(1);
    chk("R2 pulse one cycle", wdt_clr_o, 0);

    // R12 strobes ignored while asleep
    sleep_i = 1'b1; clrwdt_i = 1'b1; cyc(1); sleep_i = 1'b0; clrwdt_i = 1'b0;
    chk("R12 flags kept", fl(), 3'b100);
    chk("R12 still asleep", sleeping_o, 1);
    chk("R12 no clr pulse", wdt_clr_o, 0);

    // R7 watchdog wake
    wdt_to_i = 1'b1; cyc(1); wdt_to_i = 1'b0;
    chk("R7 disabled no wake", sleeping_o, 1);
    wdt_en_i = 1'b1; wdt_to_i = 1'b1; cyc(1); wdt_to_i = 1'b0;
    chk("R7 woke", sleeping_o, 0);
    chk("R7 flags", fl(), 3'b000);
    chk("R10 osc on", osc_en_o, 1);
    chk("R10 clr pulse", wdt_clr_o, 1);
    chk("R10 core_rst", core_rst_o, 1);
    cyc(HOLD - 1);
    chk("R10 core_rst held", core_rst_o, 1);
    cyc(1);
    chk("R10 core_rst end", core_rst_o, 0);
    wdt_en_i = 1'b0;

    // R5 external reset in normal operation
    ext_rst_i = 1'b1; cyc(3);
    chk("R5 core_rst", core_rst_o, 1);
    sleep_i = 1'b1; cyc(1); sleep_i = 1'b0;
    chk("R5 sleep ignored", sleeping_o, 0);
    chk("R5 flags kept", fl(), 3'b000);
    ext_rst_i = 1'b0; cyc(HOLD + 3);
    chk("R5 reset ends", core_rst_o, 0);
    chk("R5 flags after", fl(), 3'b000);

    // R6 / R11 external reset wake
    sleep_i = 1'b1; cyc(1); sleep_i = 1'b0;
    ext_rst_i = 1'b1; cyc(2);
    chk("R11 ext not yet", sleeping_o, 1);
    cyc(1);
    chk("R6 ext wake", sleeping_o, 0);
    chk("R6 flags kept", fl(), 3'b100);
    ext_rst_i = 1'b0; cyc(HOLD + 3);

    // R9 brown-out asleep and awake
    sleep_i = 1'b1; cyc(1); sleep_i = 1'b0;
    brownout_i = 1'b1; cyc(1); brownout_i = 1'b0;
    chk("R9 bor wake", sleeping_o, 0);
    chk("R9 bor flags asleep", fl(), 3'b110);
    cyc(HOLD + 1);
    wdt_en_i = 1'b1; wdt_to_i = 1'b1; cyc(1); wdt_to_i = 1'b0; wdt_en_i = 1'b0;
    cyc(HOLD + 1);
    brownout_i = 1'b1; cyc(1); brownout_i = 1'b0;
    chk("R9 bor flags awake", fl(), 3'b110);
    chk("R9 bor reset", core_rst_o, 1);
    cyc(HOLD + 1);

    // R8 / R11 sweep: every snapshot against every single-pin flip
    pcw_en_i = 1'b1;
    for (int base = 0; base < (1 << NP); base++) begin
      for (int b = 0; b < NP; b++) begin
        pins_i = NP'(base); cyc(3);
        sleep_i = 1'b1; cyc(1); sleep_i = 1'b0;
        chk("R8 asleep pcw clear", {sleeping_o, pcw_flag_o}, 2'b10);
        cyc(2);
        chk("R8 no spurious wake", sleeping_o, 1);
        pins_i = NP'(base) ^ NP'(1 << b); cyc(2);
        chk("R11 pin not yet", sleeping_o, 1);
        cyc(1);
        chk("R8 pin wake", sleeping_o, 0);
        chk("R8 pin flags", fl(), 3'b101);
        cyc(HOLD + 1);
      end
    end

    // R8 pin change with enable off
    pcw_en_i = 1'b0;
    sleep_i = 1'b1; cyc(1); sleep_i = 1'b0;
    pins_i = ~pins_i; cyc(6);
    chk("R8 disabled no wake", sleeping_o, 1);
    chk("R8 disabled pcw", pcw_flag_o, 0);
    wdt_en_i = 1'b1; wdt_to_i = 1'b1; cyc(1); wdt_to_i = 1'b0;
    chk("R7 exit flags", fl(), 3'b000);
    cyc(HOLD + 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cyc(100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule